// File: doc/BRIEF.md
# Conversion result store with event counting

This block sits behind an analog-to-digital converter and takes each finished 10-bit result the moment a valid strobe marks it. It places the result in a 16-bit word in one of four alignments and writes that word into a 16-word store. The host can read any word of the store by address but cannot write to it. The block counts completed results and raises a sticky event flag once a programmed number of them has arrived. The write position then returns to the start of the region being filled.

An optional split mode divides the store into two halves of eight words each. The block fills one half while the host drains the other, and the two swap roles on every event. A status output names the half that is being filled, so the host knows to read the opposite one. The converter itself, the choice of input channel and any bus decoding lie outside this block.

Top module: `cres_store`

## Requirements
- R1: With alignment code 2'b00 the stored word is the 10-bit result in bits 9:0 with bits 15:10 zero.
- R2: With alignment code 2'b01 the stored word is the result in bits 9:0 with result bit 9 copied into bits 15:10.
- R3: With alignment code 2'b10 the stored word is the result in bits 15:6 with bits 5:0 zero.
- R4: With alignment code 2'b11 the stored word is the result in bits 15:6 with bit 15 inverted, and bits 5:0 zero.
- R5: With a 4-bit count field N, the event flag is high from the clock edge that accepts the (N+1)th result counted since the previous event or reset. It is not high at any earlier point.
- R6: Once an event occurs, the next result is written at the first word of the active region. With N=0 in unsplit mode, only word 0 is written.
- R7: In split mode the lower half is words 0 to 7 and the upper half is words 8 to 15. Filling starts in the lower half when split mode is entered, and the half changes on each event. The half status output is 0 for the lower half and 1 for the upper half. It reads 0 while split mode is off.
- R8: In split mode with N greater than 7, the write position wraps inside the active half and never enters the other half.
- R9: The event flag stays high until a clear pulse arrives. If an event and a clear fall on the same edge, the flag remains high.
- R10: A read address presented at one clock edge returns its word after that edge. A read and a write to the same word at the same edge return the word's previous contents.
- R11: After reset the event flag and half status are 0, and the first result is written to word 0. The store contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_vld | input | 1 | Strobe marking a finished conversion result |
| res_data | input | 10 | Conversion result |
| cfg_count | input | 4 | Results per event, minus one |
| cfg_split | input | 1 | Run the store as two alternating halves |
| cfg_fmt | input | 2 | Alignment code for stored words |
| rd_addr | input | 4 | Host read address |
| rd_data | output | 16 | Word read, one cycle after the address |
| irq_flag | output | 1 | Sticky event flag |
| irq_clr | input | 1 | Pulse that clears the event flag |
| fill_half | output | 1 | Half currently being filled (0 lower, 1 upper) |

## Verification
Two pairs of functions can act on the same edge: a counting event and a host clear of the flag, and a result write and a host read of the same word. The bench provokes the first pair by pulsing the clear together with the result that completes the count, and expects the flag to stay high. It provokes the second pair by reading the word that is about to be written on the write edge itself, and expects the old word first and the new word on the following read.

// File: rtl/cres_pkg.sv
package cres_pkg;

    localparam int RES_W  = 10;
    localparam int WORD_W = 16;
    localparam int DEPTH  = 16;
    localparam int AW     = $clog2(DEPTH);
    localparam int PAD_W  = WORD_W - RES_W;

    typedef enum logic [1:0] {
        ALN_UINT  = 2'b00,
        ALN_SINT  = 2'b01,
        ALN_UFRAC = 2'b10,
        ALN_SFRAC = 2'b11
    } align_e;

    typedef struct packed {
        logic              en;
        logic [AW-1:0]     addr;
        logic [WORD_W-1:0] data;
    } wr_req_t;

    function automatic logic [WORD_W-1:0] align_word(input align_e mode,
                                                     input logic [RES_W-1:0] r);
        logic [WORD_W-1:0] w;
        unique case (mode)
            ALN_UINT:  w = {{PAD_W{1'b0}}, r};
            ALN_SINT:  w = {{PAD_W{r[RES_W-1]}}, r};
            ALN_UFRAC: w = {r, {PAD_W{1'b0}}};
            default:   w = {~r[RES_W-1], r[RES_W-2:0], {PAD_W{1'b0}}};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/cres_align.sv
module cres_align
    import cres_pkg::*;
(
    input  logic [1:0]        mode,
    input  logic [RES_W-1:0]  res,
    output logic [WORD_W-1:0] word
);
    always_comb begin
        word = align_word(align_e'(mode), res);
    end
endmodule

// File: rtl/cres_wctl.sv
module cres_wctl
    import cres_pkg::*;
#(
    parameter int N_WORDS = DEPTH,
    localparam int A_W    = $clog2(N_WORDS),
    localparam int HA_W   = A_W - 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           res_vld,
    input  logic [A_W-1:0] cfg_count,
    input  logic           cfg_split,
    input  logic           irq_clr,
    output logic [A_W-1:0] wr_addr,
    output logic           irq_flag,
    output logic           fill_half
);
    logic [A_W-1:0] ptr_q;
    logic           half_q;
    logic           irq_q;
    logic           evt;

    assign evt = res_vld && (ptr_q == cfg_count);

    always_comb begin
        if (cfg_split) wr_addr = {half_q, ptr_q[HA_W-1:0]};
        else           wr_addr = ptr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (res_vld) begin
            ptr_q <= evt ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !cfg_split) half_q <= 1'b0;
        else if (evt)          half_q <= ~half_q;
    end

    always_ff @(posedge clk) begin
        if (rst)          irq_q <= 1'b0;
        else if (evt)     irq_q <= 1'b1;
        else if (irq_clr) irq_q <= 1'b0;
    end

    assign irq_flag  = irq_q;
    assign fill_half = half_q;

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !irq_clr) |=> irq_q);
    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (evt && irq_clr) |=> irq_q);
    // R6
    ptr_restart_chk: assert property (@(posedge clk) disable iff (rst)
        evt |=> (ptr_q == '0));
    // R7
    half_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_split && !evt) |=> $stable(half_q));
endmodule

// File: rtl/cres_mem.sv
module cres_mem
    import cres_pkg::*;
#(
    parameter int W       = WORD_W,
    parameter int N_WORDS = DEPTH,
    localparam int A_W    = $clog2(N_WORDS)
) (
    input  logic           clk,
    input  wr_req_t        wr,
    input  logic [A_W-1:0] rd_addr,
    output logic [W-1:0]   rd_data
);
    logic [W-1:0] mem [N_WORDS];

    always_ff @(posedge clk) begin
        if (wr.en) mem[wr.addr] <= wr.data;
        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/cres_store.sv
module cres_store
    import cres_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              res_vld,
    input  logic [RES_W-1:0]  res_data,
    input  logic [AW-1:0]     cfg_count,
    input  logic              cfg_split,
    input  logic [1:0]        cfg_fmt,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              irq_flag,
    input  logic              irq_clr,
    output logic              fill_half
);
    logic [WORD_W-1:0] word;
    logic [AW-1:0]     wr_addr;
    wr_req_t           wr;

    cres_align u_align (
        .mode (cfg_fmt),
        .res  (res_data),
        .word (word)
    );

    cres_wctl #(.N_WORDS(DEPTH)) u_wctl (
        .clk       (clk),
        .rst       (rst),
        .res_vld   (res_vld),
        .cfg_count (cfg_count),
        .cfg_split (cfg_split),
        .irq_clr   (irq_clr),
        .wr_addr   (wr_addr),
        .irq_flag  (irq_flag),
        .fill_half (fill_half)
    );

    always_comb begin
        wr.en   = res_vld;
        wr.addr = wr_addr;
        wr.data = word;
    end

    cres_mem #(.W(WORD_W), .N_WORDS(DEPTH)) u_mem (
        .clk     (clk),
        .wr      (wr),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // R8
    split_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_split && res_vld) |-> (wr_addr[AW-1] == fill_half));
endmodule

// File: tb/cres_store_tb.sv
module cres_store_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        res_vld = 1'b0;
    logic [9:0]  res_data = '0;
    logic [3:0]  cfg_count = '0;
    logic        cfg_split = 1'b0;
    logic [1:0]  cfg_fmt = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        irq_flag;
    logic        irq_clr = 1'b0;
    logic        fill_half;

    int checks = 0;
    int failures = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    bit          done = 1'b0;

    always #5 clk = ~clk;

    cres_store u_dut (
        .clk(clk), .rst(rst), .res_vld(res_vld), .res_data(res_data),
        .cfg_count(cfg_count), .cfg_split(cfg_split), .cfg_fmt(cfg_fmt),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_flag(irq_flag),
        .irq_clr(irq_clr), .fill_half(fill_half)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read words after the edge that registers them
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end

    task automatic send(input logic [9:0] d);
        res_vld = 1'b1; res_data = d;
        @(negedge clk);
        res_vld = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [15:0] e, input string tag);
        rd_addr = a; exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic send_rd(input logic [9:0] d, input logic [3:0] a,
                           input logic [15:0] e, input string tag);
        res_vld = 1'b1; res_data = d; rd_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        res_vld = 1'b0;
    endtask

    task automatic clr();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        check("R11 irq after reset", {15'b0, irq_flag}, 16'h0);
        check("R11 half after reset", {15'b0, fill_half}, 16'h0);

        // R5 count of four, unsigned integer alignment
        cfg_count = 4'd3; cfg_fmt = 2'b00;
        send(10'h3FF); send(10'h001); send(10'h200);
        check("R5 no event before count", {15'b0, irq_flag}, 16'h0);
        send(10'h155);
        check("R5 event at count", {15'b0, irq_flag}, 16'h1);
        rd(4'd0, 16'h03FF, "R1 word0");
        rd(4'd1, 16'h0001, "R1 word1");
        rd(4'd2, 16'h0200, "R1 word2");
        rd(4'd3, 16'h0155, "R11 R1 word3");
        repeat (3) @(negedge clk);
        check("R9 flag sticky", {15'b0, irq_flag}, 16'h1);
        clr();
        check("R9 flag cleared", {15'b0, irq_flag}, 16'h0);

        // R2 signed integer, restart at word 0 (R6)
        cfg_fmt = 2'b01;
        send(10'h200); send(10'h1FF); send(10'h3FF); send(10'h000);
        rd(4'd0, 16'hFE00, "R2 R6 word0");
        rd(4'd1, 16'h01FF, "R2 word1");
        rd(4'd2, 16'hFFFF, "R2 word2");
        rd(4'd3, 16'h0000, "R2 word3");
        clr();

        // R3 unsigned fraction with N=0: only word 0 written (R6)
        cfg_count = 4'd0; cfg_fmt = 2'b10;
        send(10'h3FF);
        rd(4'd0, 16'hFFC0, "R3 word0 a");
        send(10'h001);
        rd(4'd0, 16'h0040, "R3 word0 b");
        rd(4'd1, 16'h01FF, "R6 word1 untouched");

        // R4 signed fraction; event coinciding with clear keeps flag (R9)
        cfg_fmt = 2'b11;
        clr();
        irq_clr = 1'b1; send(10'h200); irq_clr = 1'b0;
        check("R9 set wins over clear", {15'b0, irq_flag}, 16'h1);
        rd(4'd0, 16'h0000, "R4 0x200");
        send(10'h1FF); rd(4'd0, 16'hFFC0, "R4 0x1FF");
        send(10'h3FF); rd(4'd0, 16'h7FC0, "R4 0x3FF");
        send(10'h000); rd(4'd0, 16'h8000, "R4 0x000");
        clr();

        // R7 split halves, two results per event
        cfg_fmt = 2'b00; cfg_count = 4'd1; cfg_split = 1'b1;
        @(negedge clk);
        check("R7 starts lower", {15'b0, fill_half}, 16'h0);
        send(10'h011); send(10'h022);
        check("R7 moved to upper", {15'b0, fill_half}, 16'h1);
        send(10'h033); send(10'h044);
        check("R7 back to lower", {15'b0, fill_half}, 16'h0);
        send(10'h055);
        rd(4'd0, 16'h0055, "R7 lower word0 refilled");
        rd(4'd1, 16'h0022, "R7 lower word1");
        rd(4'd8, 16'h0033, "R7 upper word8");
        rd(4'd9, 16'h0044, "R7 upper word9");
        send(10'h066);
        cfg_split = 1'b0;
        @(negedge clk);
        check("R7 half zero when unsplit", {15'b0, fill_half}, 16'h0);

        // R8 count of twelve in split mode wraps inside lower half
        cfg_split = 1'b1; cfg_count = 4'd11;
        for (int i = 0; i < 12; i++) send(10'h100 + 10'(i));
        check("R8 half after wrap event", {15'b0, fill_half}, 16'h1);
        rd(4'd0, 16'h0108, "R8 word0 wrapped");
        rd(4'd3, 16'h010B, "R8 word3 wrapped");
        rd(4'd4, 16'h0104, "R8 word4 single write");
        rd(4'd8, 16'h0033, "R8 upper untouched");
        clr();

        // R10 same-edge read and write of word 8
        cfg_count = 4'd0;
        send_rd(10'h3AA, 4'd8, 16'h0033, "R10 old word on collision");
        rd(4'd8, 16'h03AA, "R10 new word after");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule